// File: doc/BRIEF.md
# Legacy Keyboard Controller Port Emulation

This block lets emulation firmware present a USB keyboard and mouse to the host as if they sat behind the classic keyboard controller at I/O addresses 60h (data) and 64h (command/status). While emulation is enabled, host reads and writes to those two addresses are trapped. A written byte is held in an input byte register, and a set of status flags tracks whether it still waits for firmware and whether it came in as a command or as data. The host reads the data port to collect a byte that firmware has placed in the output byte register. It reads the command port to get the status byte.

Firmware reaches the block through a small register window of four word-aligned registers starting at a parameterised offset (100h by default): control at +0, input byte at +4, output byte at +8 and status at +Ch. Each register carries one byte on the low lanes of an 8-bit software data bus. The block raises an emulation interrupt while a host byte waits for firmware. It raises either the keyboard line (IRQ1) or the mouse line (IRQ12) while an output byte waits for the host, depending on a routing bit that firmware sets in the status register.

Top module: `kbc_legacy_emu`

## Requirements
- R1: After reset all flags, both byte registers, the control bits and the three interrupt outputs are 0, and a status read returns 00h.
- R2: A host access is trapped (host_trapped=1) only when the control emulation-enable bit (control bit 0) is 1 and the address equals the data port (60h) or the command port (64h). With the bit at 0, host_trapped is 0, host_rdata is 0, and no flag or byte register changes.
- R3: A trapped host write to the data port loads the byte into the input byte register, sets input-full and clears command/data.
- R4: A trapped host write to the command port loads the byte into the input byte register, sets input-full and sets command/data.
- R5: A trapped host read of the data port returns the output byte in the same cycle and clears output-full.
- R6: A trapped host read of the command port returns the status byte and changes no flag. Status byte layout: bit 0 output-full, bit 1 input-full, bit 3 command/data, bit 5 mouse routing, all other bits 0.
- R7: A software write to the output register (+8h) loads the byte and sets output-full. When a host data-port read falls in the same cycle, output-full ends up set.
- R8: A software read of the input register (+4h) returns the input byte and clears input-full. When a trapped host write falls in the same cycle, input-full ends up set and the new byte is held.
- R9: One cycle after the flags allow it, irq_kbd is 1 exactly when emulation-enable, interrupt-enable (control bit 1) and output-full are all 1 and the routing bit is 0. irq_mouse is 1 under the same conditions with the routing bit at 1. The routing bit is written through status register bit 5, and no other status bit is writable.
- R10: One cycle after the flags allow it, emu_irq is 1 exactly when emulation-enable and input-full are both 1.
- R11: The control register reads back bits 0 and 1. A software read of a misaligned offset or of an offset outside the four registers returns 0, and a software write there changes nothing.
- R12: While emulation is enabled, a host access to any address other than the two ports is not trapped, returns 0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host I/O access present this cycle |
| host_write | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte returned to the host (0 when not trapped) |
| host_trapped | output | 1 | The access was claimed by the emulation |
| sw_valid | input | 1 | Firmware register access present this cycle |
| sw_write | input | 1 | 1 = firmware write, 0 = firmware read |
| sw_addr | input | 9 | Byte offset from the operational register base |
| sw_wdata | input | 8 | Firmware write byte |
| sw_rdata | output | 8 | Firmware read byte |
| irq_kbd | output | 1 | Keyboard interrupt (IRQ1) |
| irq_mouse | output | 1 | Mouse interrupt (IRQ12) |
| emu_irq | output | 1 | Emulation service interrupt |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions, where a host data-port read meets a firmware output write, or a firmware input read meets a host write. Both rules decide which side wins. The bench drives both interfaces in one cycle on purpose and then reads the status back through the firmware window. A second hard case is a host access while emulation is disabled and the flags are non-zero. The bench reaches it by filling the output byte, clearing the enable bit and then probing both ports, so that an unwanted side effect would show in the status byte. Around these cases, every byte value is swept through both host ports and through the output register, and all combinations of the two control bits, the routing bit and output-full are swept for the interrupt lines.

// File: rtl/kbc_emu_pkg.sv
package kbc_emu_pkg;

   // status byte bit positions (decoded by host software)
   localparam int ST_OUT_FULL = 0;
   localparam int ST_IN_FULL  = 1;
   localparam int ST_CMD      = 3;
   localparam int ST_AUX      = 5;

   // control register bit positions
   localparam int CT_EMU_EN   = 0;
   localparam int CT_IRQ_EN   = 1;

   // register index inside the firmware window
   typedef enum logic [1:0] {
      RIDX_CTRL = 2'd0,
      RIDX_IN   = 2'd1,
      RIDX_OUT  = 2'd2,
      RIDX_STAT = 2'd3
   } reg_idx_e;

   localparam int NUM_REGS = 4;

   // interrupt line index
   localparam int IRQ_KBD   = 0;
   localparam int IRQ_MOUSE = 1;
   localparam int NUM_IRQ   = 2;

endpackage

// File: rtl/kbc_host_port.sv
module kbc_host_port #(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
   parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
   input  logic              host_valid,
   input  logic              host_write,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              emu_en,
   input  logic [DATA_W-1:0] out_data,
   input  logic [DATA_W-1:0] status_byte,
   output logic              data_wr,
   output logic              cmd_wr,
   output logic              data_rd,
   output logic              trapped,
   output logic [DATA_W-1:0] rdata
);

   logic hit_data;
   logic hit_cmd;
   logic claim;

   assign hit_data = (host_addr == DATA_PORT);
   assign hit_cmd  = (host_addr == CMD_PORT);
   assign claim    = host_valid & emu_en & (hit_data | hit_cmd);

   assign trapped  = claim;
   assign data_wr  = claim & host_write & hit_data;
   assign cmd_wr   = claim & host_write & hit_cmd;
   assign data_rd  = claim & ~host_write & hit_data;

   always_comb begin
      rdata = '0;
      if (claim && !host_write) begin
         if (hit_data) rdata = out_data;
         else          rdata = status_byte;
      end
   end

endmodule

// File: rtl/kbc_sw_regs.sv
module kbc_sw_regs
   import kbc_emu_pkg::*;
#(
   parameter int                   SW_ADDR_W = 9,
   parameter int                   DATA_W    = 8,
   parameter logic [SW_ADDR_W-1:0] CTRL_OFS  = 'h100
) (
   input  logic                 sw_valid,
   input  logic                 sw_write,
   input  logic [SW_ADDR_W-1:0] sw_addr,
   input  logic                 emu_en,
   input  logic                 irq_en,
   input  logic [DATA_W-1:0]    in_data,
   input  logic [DATA_W-1:0]    out_data,
   input  logic [DATA_W-1:0]    status_byte,
   output logic                 ctrl_wr,
   output logic                 in_rd,
   output logic                 out_wr,
   output logic                 stat_wr,
   output logic [DATA_W-1:0]    sw_rdata
);

   localparam int              WORD_W    = SW_ADDR_W - 2;
   localparam logic [WORD_W-1:0] BASE_WORD = CTRL_OFS[SW_ADDR_W-1:2];

   logic [WORD_W-1:0]   word;
   logic                aligned;
   logic [NUM_REGS-1:0] hit;

   assign word    = sw_addr[SW_ADDR_W-1:2];
   assign aligned = (sw_addr[1:0] == 2'b00);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
      localparam logic [WORD_W-1:0] MY_WORD = BASE_WORD + WORD_W'(g);
      assign hit[g] = sw_valid & aligned & (word == MY_WORD);
   end

   assign ctrl_wr = hit[int'(RIDX_CTRL)] &  sw_write;
   assign in_rd   = hit[int'(RIDX_IN)]   & ~sw_write;
   assign out_wr  = hit[int'(RIDX_OUT)]  &  sw_write;
   assign stat_wr = hit[int'(RIDX_STAT)] &  sw_write;

   always_comb begin
      sw_rdata = '0;
      if (!sw_write) begin
         if (hit[int'(RIDX_CTRL)]) begin
            sw_rdata[CT_EMU_EN] = emu_en;
            sw_rdata[CT_IRQ_EN] = irq_en;
         end
         if (hit[int'(RIDX_IN)])   sw_rdata = in_data;
         if (hit[int'(RIDX_OUT)])  sw_rdata = out_data;
         if (hit[int'(RIDX_STAT)]) sw_rdata = status_byte;
      end
   end

endmodule

// File: rtl/kbc_emu_state.sv
module kbc_emu_state
   import kbc_emu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic              cmd_wr,
   input  logic              data_rd,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              ctrl_wr,
   input  logic              in_rd,
   input  logic              out_wr,
   input  logic              stat_wr,
   input  logic [DATA_W-1:0] sw_wdata,
   output logic              emu_en,
   output logic              irq_en,
   output logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] out_data,
   output logic              in_full,
   output logic              out_full,
   output logic              cmd_data,
   output logic              aux,
   output logic [DATA_W-1:0] status_byte
);

   logic host_wr;
   assign host_wr = data_wr | cmd_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         emu_en   <= 1'b0;
         irq_en   <= 1'b0;
         in_data  <= '0;
         out_data <= '0;
         in_full  <= 1'b0;
         out_full <= 1'b0;
         cmd_data <= 1'b0;
         aux      <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            emu_en <= sw_wdata[CT_EMU_EN];
            irq_en <= sw_wdata[CT_IRQ_EN];
         end
         if (host_wr) begin
            in_data  <= host_wdata;
            cmd_data <= cmd_wr;
         end
         // a set by the host outranks a clear by firmware
         if (host_wr)    in_full <= 1'b1;
         else if (in_rd) in_full <= 1'b0;
         if (out_wr) out_data <= sw_wdata;
         // a fill by firmware outranks a drain by the host
         if (out_wr)       out_full <= 1'b1;
         else if (data_rd) out_full <= 1'b0;
         if (stat_wr) aux <= sw_wdata[ST_AUX];
      end
   end

   always_comb begin
      status_byte              = '0;
      status_byte[ST_OUT_FULL] = out_full;
      status_byte[ST_IN_FULL]  = in_full;
      status_byte[ST_CMD]      = cmd_data;
      status_byte[ST_AUX]      = aux;
   end

endmodule

// File: rtl/kbc_irq_gen.sv
module kbc_irq_gen
   import kbc_emu_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               emu_en,
   input  logic               irq_en,
   input  logic               out_full,
   input  logic               in_full,
   input  logic               aux,
   output logic [NUM_IRQ-1:0] irq_q,
   output logic               emu_irq_q
);

   logic [NUM_IRQ-1:0] irq_raw;
   logic               gate;

   assign gate = emu_en & irq_en & out_full;

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
      assign irq_raw[g] = gate & (aux == ((g == IRQ_MOUSE) ? 1'b1 : 1'b0));
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q[g] <= 1'b0;
         else        irq_q[g] <= irq_raw[g];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) emu_irq_q <= 1'b0;
      else        emu_irq_q <= emu_en & in_full;
   end

endmodule

// File: rtl/kbc_legacy_emu.sv
module kbc_legacy_emu
   import kbc_emu_pkg::*;
#(
   parameter int                   ADDR_W    = 16,
   parameter int                   DATA_W    = 8,
   parameter int                   SW_ADDR_W = 9,
   parameter logic [ADDR_W-1:0]    DATA_PORT = 'h60,
   parameter logic [ADDR_W-1:0]    CMD_PORT  = 'h64,
   parameter logic [SW_ADDR_W-1:0] CTRL_OFS  = 'h100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_valid,
   input  logic                 host_write,
   input  logic [ADDR_W-1:0]    host_addr,
   input  logic [DATA_W-1:0]    host_wdata,
   output logic [DATA_W-1:0]    host_rdata,
   output logic                 host_trapped,
   input  logic                 sw_valid,
   input  logic                 sw_write,
   input  logic [SW_ADDR_W-1:0] sw_addr,
   input  logic [DATA_W-1:0]    sw_wdata,
   output logic [DATA_W-1:0]    sw_rdata,
   output logic                 irq_kbd,
   output logic                 irq_mouse,
   output logic                 emu_irq
);

   initial begin
      assert (DATA_W >= 8) else $error("DATA_W must hold the status byte");
      assert (DATA_PORT != CMD_PORT) else $error("ports must differ");
      assert (SW_ADDR_W >= 4) else $error("SW_ADDR_W too small");
      assert (CTRL_OFS[1:0] == 2'b00) else $error("CTRL_OFS must be word aligned");
      assert ((int'(CTRL_OFS) + 4 * NUM_REGS) <= (1 << SW_ADDR_W))
         else $error("register window exceeds address space");
   end

   logic              emu_en, irq_en;
   logic [DATA_W-1:0] in_data, out_data, status_byte;
   logic              in_full, out_full, cmd_data, aux;
   logic              data_wr, cmd_wr, data_rd;
   logic              ctrl_wr, in_rd, out_wr, stat_wr;
   logic [NUM_IRQ-1:0] irq_q;

   kbc_host_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
   ) u_host (
      .host_valid (host_valid),
      .host_write (host_write),
      .host_addr  (host_addr),
      .emu_en     (emu_en),
      .out_data   (out_data),
      .status_byte(status_byte),
      .data_wr    (data_wr),
      .cmd_wr     (cmd_wr),
      .data_rd    (data_rd),
      .trapped    (host_trapped),
      .rdata      (host_rdata)
   );

   kbc_sw_regs #(
      .SW_ADDR_W(SW_ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS)
   ) u_regs (
      .sw_valid   (sw_valid),
      .sw_write   (sw_write),
      .sw_addr    (sw_addr),
      .emu_en     (emu_en),
      .irq_en     (irq_en),
      .in_data    (in_data),
      .out_data   (out_data),
      .status_byte(status_byte),
      .ctrl_wr    (ctrl_wr),
      .in_rd      (in_rd),
      .out_wr     (out_wr),
      .stat_wr    (stat_wr),
      .sw_rdata   (sw_rdata)
   );

   kbc_emu_state #(.DATA_W(DATA_W)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_wr    (data_wr),
      .cmd_wr     (cmd_wr),
      .data_rd    (data_rd),
      .host_wdata (host_wdata),
      .ctrl_wr    (ctrl_wr),
      .in_rd      (in_rd),
      .out_wr     (out_wr),
      .stat_wr    (stat_wr),
      .sw_wdata   (sw_wdata),
      .emu_en     (emu_en),
      .irq_en     (irq_en),
      .in_data    (in_data),
      .out_data   (out_data),
      .in_full    (in_full),
      .out_full   (out_full),
      .cmd_data   (cmd_data),
      .aux        (aux),
      .status_byte(status_byte)
   );

   kbc_irq_gen u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .emu_en   (emu_en),
      .irq_en   (irq_en),
      .out_full (out_full),
      .in_full  (in_full),
      .aux      (aux),
      .irq_q    (irq_q),
      .emu_irq_q(emu_irq)
   );

   assign irq_kbd   = irq_q[IRQ_KBD];
   assign irq_mouse = irq_q[IRQ_MOUSE];

endmodule

// File: rtl/kbc_legacy_emu_chk.sv
module kbc_legacy_emu_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_valid,
   input logic              host_write,
   input logic              host_trapped,
   input logic [DATA_W-1:0] host_rdata,
   input logic [DATA_W-1:0] host_wdata,
   input logic              sw_valid,
   input logic              emu_en,
   input logic              irq_en,
   input logic              in_full,
   input logic              out_full,
   input logic              cmd_data,
   input logic              aux,
   input logic [DATA_W-1:0] in_data,
   input logic              data_wr,
   input logic              cmd_wr,
   input logic              data_rd,
   input logic              out_wr,
   input logic              in_rd,
   input logic              irq_kbd,
   input logic              irq_mouse,
   input logic              emu_irq
);

   // R2
   pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_valid && !emu_en |-> !host_trapped && host_rdata == '0);

   // R2
   no_side_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_valid && !emu_en && !sw_valid |=>
         $stable(in_full) && $stable(out_full) && $stable(in_data) && $stable(cmd_data));

   // R3
   data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> in_full && !cmd_data && in_data == $past(host_wdata));

   // R4
   cmd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> in_full && cmd_data && in_data == $past(host_wdata));

   // R5
   out_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd && !out_wr |=> !out_full);

   // R6
   status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_trapped && !host_write && !data_rd |->
         host_rdata[DATA_W-1:6] == '0 && !host_rdata[4] && !host_rdata[2] &&
         host_rdata[0] == out_full && host_rdata[1] == in_full);

   // R7
   out_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |=> out_full);

   // R8
   in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_rd && !data_wr && !cmd_wr |=> !in_full);

   // R9
   irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_kbd && irq_mouse));

   // R9
   irq_kbd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_kbd |-> $past(emu_en && irq_en && out_full && !aux));

   // R9
   irq_mouse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mouse |-> $past(emu_en && irq_en && out_full && aux));

   // R10
   emu_irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_full) && emu_en |=> emu_irq);

   // R10
   emu_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      emu_irq |-> $past(in_full && emu_en));

endmodule

bind kbc_legacy_emu kbc_legacy_emu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_kbc_legacy_emu.sv
module tb_kbc_legacy_emu;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] DP   = 16'h0060;
   localparam logic [15:0] CP   = 16'h0064;
   localparam logic [8:0]  O_CT = 9'h100;
   localparam logic [8:0]  O_IN = 9'h104;
   localparam logic [8:0]  O_OU = 9'h108;
   localparam logic [8:0]  O_ST = 9'h10C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_valid = 1'b0, host_write = 1'b0;
   logic [15:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       host_trapped;
   logic       sw_valid = 1'b0, sw_write = 1'b0;
   logic [8:0] sw_addr = '0;
   logic [7:0] sw_wdata = '0;
   logic [7:0] sw_rdata;
   logic       irq_kbd, irq_mouse, emu_irq;

   int n_checks = 0;
   int n_fail   = 0;

   // bench-side model of the flags
   bit       m_in_full, m_out_full, m_cmd, m_aux, m_en, m_ien;
   logic [7:0] m_in, m_out;

   logic [7:0] h_rd, s_rd;
   logic       h_tr;

   always #(CLK_PERIOD/2) clk = ~clk;

   kbc_legacy_emu dut (
      .clk(clk), .rst_n(rst_n),
      .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_trapped(host_trapped),
      .sw_valid(sw_valid), .sw_write(sw_write), .sw_addr(sw_addr),
      .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
      .irq_kbd(irq_kbd), .irq_mouse(irq_mouse), .emu_irq(emu_irq)
   );

   function automatic logic [7:0] stat_exp();
      return {2'b00, m_aux, 1'b0, m_cmd, 1'b0, m_in_full, m_out_full};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, got, exp);
      end
   endtask

   task automatic cyc(input bit hv, input bit hw, input logic [15:0] ha, input logic [7:0] hd,
                      input bit sv, input bit sw, input logic [8:0] sa, input logic [7:0] sd);
      @(negedge clk);
      host_valid = hv; host_write = hw; host_addr = ha; host_wdata = hd;
      sw_valid = sv; sw_write = sw; sw_addr = sa; sw_wdata = sd;
      #1;
      h_rd = host_rdata; h_tr = host_trapped; s_rd = sw_rdata;
      @(posedge clk);
      #1;
      host_valid = 1'b0; sw_valid = 1'b0;
   endtask

   task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
      cyc(1, 1, a, d, 0, 0, '0, '0);
   endtask
   task automatic host_rd(input logic [15:0] a);
      cyc(1, 0, a, '0, 0, 0, '0, '0);
   endtask
   task automatic sw_wr(input logic [8:0] a, input logic [7:0] d);
      cyc(0, 0, '0, '0, 1, 1, a, d);
   endtask
   task automatic sw_rd(input logic [8:0] a);
      cyc(0, 0, '0, '0, 1, 0, a, '0);
   endtask
   task automatic idle();
      @(posedge clk);
      #1;
   endtask

   task automatic check_status(input string req);
      sw_rd(O_ST);
      check(s_rd == stat_exp(), req, "status", s_rd, stat_exp());
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle();

      // R1: reset state
      check(irq_kbd == 0, "R1", "irq_kbd", {7'd0, irq_kbd}, 8'h00);
      check(irq_mouse == 0, "R1", "irq_mouse", {7'd0, irq_mouse}, 8'h00);
      check(emu_irq == 0, "R1", "emu_irq", {7'd0, emu_irq}, 8'h00);
      check_status("R1");
      sw_rd(O_CT);
      check(s_rd == 8'h00, "R1", "control", s_rd, 8'h00);
      sw_rd(O_IN);
      check(s_rd == 8'h00, "R1", "input byte", s_rd, 8'h00);

      // R2: emulation disabled, no trap and no side effect
      host_wr(DP, 8'hA5);
      check(h_tr == 0, "R2", "trap while disabled", {7'd0, h_tr}, 8'h00);
      host_rd(CP);
      check(h_tr == 0, "R2", "trap on read while disabled", {7'd0, h_tr}, 8'h00);
      check(h_rd == 8'h00, "R2", "rdata while disabled", h_rd, 8'h00);
      check_status("R2");
      sw_rd(O_IN);
      check(s_rd == 8'h00, "R2", "input byte untouched", s_rd, 8'h00);

      // R11: enable and read back control
      sw_wr(O_CT, 8'h01); m_en = 1;
      sw_rd(O_CT);
      check(s_rd == 8'h01, "R11", "control readback", s_rd, 8'h01);

      // R3 R4 R6 R8 R10: sweep every byte through both ports
      for (int d = 0; d < 256; d++) begin
         host_wr(DP, 8'(d));
         check(h_tr == 1, "R2", "data-port trap", {7'd0, h_tr}, 8'h01);
         m_in = 8'(d); m_in_full = 1; m_cmd = 0;
         check_status("R3");
         check(emu_irq == 1, "R10", "emu_irq set", {7'd0, emu_irq}, 8'h01);
         sw_rd(O_IN);
         check(s_rd == m_in, "R8", "input byte", s_rd, m_in);
         m_in_full = 0;
         idle();
         check(emu_irq == 0, "R10", "emu_irq cleared", {7'd0, emu_irq}, 8'h00);
         host_wr(CP, ~8'(d));
         m_in = ~8'(d); m_in_full = 1; m_cmd = 1;
         check_status("R4");
         sw_rd(O_IN);
         check(s_rd == m_in, "R4", "command byte", s_rd, m_in);
         m_in_full = 0;
         host_rd(CP);
         check(h_rd == stat_exp(), "R6", "host status read", h_rd, stat_exp());
      end
      check_status("R6");

      // R5 R7: sweep every byte through the output register
      for (int d = 0; d < 256; d++) begin
         sw_wr(O_OU, 8'(d));
         m_out = 8'(d); m_out_full = 1;
         host_rd(CP);
         check(h_rd == stat_exp(), "R7", "output-full in status", h_rd, stat_exp());
         host_rd(DP);
         check(h_rd == m_out, "R5", "host data read", h_rd, m_out);
         m_out_full = 0;
         host_rd(CP);
         check(h_rd == stat_exp(), "R5", "output-full cleared", h_rd, stat_exp());
      end

      // R9: control bits x routing x output-full
      for (int ce = 0; ce < 4; ce++) begin
         for (int a = 0; a < 2; a++) begin
            for (int f = 0; f < 2; f++) begin
               sw_wr(O_CT, 8'(ce));
               sw_wr(O_ST, (a != 0) ? 8'hFF : 8'h00);
               m_aux = (a != 0);
               if (f != 0) begin
                  sw_wr(O_OU, 8'h3C);
                  m_out = 8'h3C; m_out_full = 1;
               end
               idle();
               check(irq_kbd == (ce == 3 && f == 1 && a == 0), "R9", "irq_kbd",
                     {7'd0, irq_kbd}, {7'd0, (ce == 3 && f == 1 && a == 0)});
               check(irq_mouse == (ce == 3 && f == 1 && a == 1), "R9", "irq_mouse",
                     {7'd0, irq_mouse}, {7'd0, (ce == 3 && f == 1 && a == 1)});
               check_status("R9");
               sw_wr(O_CT, 8'h01);
               host_rd(DP);
               m_out_full = 0;
            end
         end
      end
      sw_wr(O_ST, 8'h00); m_aux = 0;
      check_status("R9");

      // R7: firmware fill and host drain in the same cycle
      sw_wr(O_OU, 8'h11); m_out = 8'h11; m_out_full = 1;
      cyc(1, 0, DP, '0, 1, 1, O_OU, 8'h5A);
      check(h_rd == 8'h11, "R7", "collision host read old byte", h_rd, 8'h11);
      m_out = 8'h5A; m_out_full = 1;
      check_status("R7");
      host_rd(DP);
      check(h_rd == 8'h5A, "R7", "collision new byte", h_rd, 8'h5A);
      m_out_full = 0;

      // R8: firmware read and host write in the same cycle
      host_wr(DP, 8'h21); m_in = 8'h21; m_in_full = 1; m_cmd = 0;
      cyc(1, 1, DP, 8'hC3, 1, 0, O_IN, '0);
      check(s_rd == 8'h21, "R8", "collision firmware old byte", s_rd, 8'h21);
      m_in = 8'hC3; m_in_full = 1;
      check_status("R8");
      sw_rd(O_IN);
      check(s_rd == 8'hC3, "R8", "collision new byte", s_rd, 8'hC3);
      m_in_full = 0;

      // R12: other addresses with emulation enabled
      host_wr(16'h0061, 8'h99);
      check(h_tr == 0, "R12", "trap at 61h", {7'd0, h_tr}, 8'h00);
      host_wr(16'h0164, 8'h99);
      check(h_tr == 0, "R12", "trap at 164h", {7'd0, h_tr}, 8'h00);
      host_rd(16'h0065);
      check(h_rd == 8'h00, "R12", "rdata at 65h", h_rd, 8'h00);
      check_status("R12");
      sw_rd(O_IN);
      check(s_rd == 8'hC3, "R12", "input byte untouched", s_rd, 8'hC3);

      // R11: unmapped and misaligned firmware accesses
      sw_wr(9'h110, 8'hFF);
      sw_wr(9'h101, 8'hFF);
      sw_rd(O_CT);
      check(s_rd == 8'h01, "R11", "control after stray writes", s_rd, 8'h01);
      sw_rd(9'h110);
      check(s_rd == 8'h00, "R11", "unmapped read", s_rd, 8'h00);
      sw_rd(9'h101);
      check(s_rd == 8'h00, "R11", "misaligned read", s_rd, 8'h00);
      sw_rd(9'h0FC);
      check(s_rd == 8'h00, "R11", "below window read", s_rd, 8'h00);
      check_status("R11");

      // R2: flags set, then emulation disabled
      sw_wr(O_OU, 8'h77); m_out = 8'h77; m_out_full = 1;
      sw_wr(O_CT, 8'h02); m_en = 0;
      host_rd(DP);
      check(h_tr == 0, "R2", "trap disabled read", {7'd0, h_tr}, 8'h00);
      check(h_rd == 8'h00, "R2", "rdata disabled read", h_rd, 8'h00);
      host_wr(CP, 8'h44);
      check(h_tr == 0, "R2", "trap disabled write", {7'd0, h_tr}, 8'h00);
      check_status("R2");
      idle();
      check(irq_kbd == 0, "R2", "irq_kbd disabled", {7'd0, irq_kbd}, 8'h00);
      sw_rd(O_IN);
      check(s_rd == 8'hC3, "R2", "input byte disabled", s_rd, 8'hC3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule